// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Store with Match

This block keeps one tag and three status flags for every line of a direct-mapped cache, and answers in the same cycle whether a probe tag hits the line picked by the address. The tag output, the status output and the hit flag are all combinational from the address and the probe tag. Tag and status writes are committed on the rising clock edge. The tag field and the status field each have their own write strobe and output enable. A clear input wipes every status flag in the array in one clock, which is how the cache invalidates all of its lines at once.

A mode input sets the meaning of the flags. In dedicated mode bit 0 is the valid flag, bit 1 the dirty flag and bit 2 the write-through flag, and a stored valid of 0 suppresses the hit. In generic mode the three flags are free user bits and the hit depends only on the tag compare. Two chip selects and a power-down input gate the whole block. The pad drivers of a packaged part are modelled here as output-enable flags beside each output. The block has no streaming data path, so every pin is a plain level-sensitive control or data signal.

The address width is a parameter. The default is 8 bits (256 lines). Set `ADDR_W` to 14 for a 16K-line array.

Top module: `ctag_store`

## Requirements
- R1: In dedicated mode (`generic_mode`=0), with the block active, `hit` is 1 when `probe_tag` equals the tag stored at `addr` and the stored status bit 0 (valid) is 1.
- R2: With the block active, `hit` is 0 whenever `probe_tag` differs from the stored tag at `addr`.
- R3: In dedicated mode, a stored valid bit (status bit 0) of 0 forces `hit` to 0 even when the tags are equal.
- R4: In generic mode (`generic_mode`=1), `hit` follows only the tag compare, whatever the stored status bits are.
- R5: Reads are combinational: with no write strobe low, `tag_out` and `stat_out` show the contents at the current `addr` in the same cycle. A write becomes visible after the rising edge at which its strobe is low.
- R6: `tag_wr_n` writes only the tag field and `stat_wr_n` writes only the status field. Each leaves the other field at that address unchanged.
- R7: `tag_out_en` is 1 exactly when the block is active and `tag_oe_n` is 0. `stat_out_en` is 1 exactly when the block is active and `stat_oe_n` is 0.
- R8: When `clr_n` is 0 at a rising edge, every status bit at every address becomes 0. A status write in that same cycle is dropped. A tag write in that cycle still lands. Clear acts whether or not the block is selected.
- R9: The block is active only when `sel_a_n`=0, `sel_b`=1 and `pwr_n`=1. When it is inactive, `hit`, `hit_en`, `tag_out_en` and `stat_out_en` are all 0, and tag and status writes are ignored.
- R10: While a field's write strobe is low, that field's output shows the data being written (`tag_in` or `stat_in`), not the stored value.
- R11: During a tag write, the compare uses the tag stored before the edge, not `tag_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the clear act on its rising edge |
| clr_n | input | 1 | Active-low synchronous clear of all status bits |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| pwr_n | input | 1 | Active-low power-down; 0 disables the block |
| generic_mode | input | 1 | 0: dedicated status meaning; 1: generic user bits |
| addr | input | ADDR_W | Line address |
| tag_in | input | TAG_W | Probe tag and tag write data |
| stat_in | input | 3 | Status write data (bit 0 valid, bit 1 dirty, bit 2 write-through) |
| tag_wr_n | input | 1 | Active-low tag write strobe |
| stat_wr_n | input | 1 | Active-low status write strobe |
| tag_oe_n | input | 1 | Active-low tag output enable |
| stat_oe_n | input | 1 | Active-low status output enable |
| tag_out | output | TAG_W | Tag read data |
| tag_out_en | output | 1 | Drive flag for tag_out |
| stat_out | output | 3 | Status read data |
| stat_out_en | output | 1 | Drive flag for stat_out |
| hit | output | 1 | Match result |
| hit_en | output | 1 | Drive flag for hit |

## Verification
The bench probes lines whose tag matches while the valid flag is clear. A design that ignored the mode would report a hit on an invalidated line in dedicated mode, or lose genuine hits in generic mode. It runs a clear in the same cycle as a status write and a tag write: a flawed priority either lets the written status survive the clear or loses the tag. It compares while a tag write is in flight, which catches a compare wired to `tag_in` instead of the stored tag. It also attempts writes while deselected or powered down, and a design that did not gate its strobes would corrupt those lines.

// File: rtl/ctag_pkg.sv
`timescale 1ns/1ps
package ctag_pkg;
  localparam int STAT_W = 3;
  localparam int VALID_BIT = 0;

  typedef struct packed {
    logic wthru;
    logic dirty;
    logic valid;
  } ctag_stat_t;
endpackage

// File: rtl/ctag_tag_mem.sv
`timescale 1ns/1ps
module ctag_tag_mem #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  wdata,
  output logic [TAG_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/ctag_stat_array.sv
`timescale 1ns/1ps
module ctag_stat_array
  import ctag_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  ctag_stat_t        wdata,
  output ctag_stat_t        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  ctag_stat_t line_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!clr_n)
        line_q[i] <= '0;
      else if (we && (addr == ADDR_W'(i)))
        line_q[i] <= wdata;
    end
  end

  assign rdata = line_q[addr];
endmodule

// File: rtl/ctag_cmp.sv
`timescale 1ns/1ps
module ctag_cmp #(
  parameter int TAG_W = 12
) (
  input  logic             active,
  input  logic             generic_mode,
  input  logic             stored_valid,
  input  logic [TAG_W-1:0] stored_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit
);
  logic tag_eq;
  logic qual;

  always_comb begin
    tag_eq = (stored_tag == probe_tag);
    qual   = generic_mode | stored_valid;
    hit    = active & tag_eq & qual;
  end
endmodule

// File: rtl/ctag_store.sv
`timescale 1ns/1ps
module ctag_store
  import ctag_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              pwr_n,
  input  logic              generic_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              tag_wr_n,
  input  logic              stat_wr_n,
  input  logic              tag_oe_n,
  input  logic              stat_oe_n,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_out_en,
  output logic [STAT_W-1:0] stat_out,
  output logic              stat_out_en,
  output logic              hit,
  output logic              hit_en
);
  logic             active;
  logic             tag_we;
  logic             stat_we;
  logic [TAG_W-1:0] tag_rd;
  ctag_stat_t       stat_rd;
  ctag_stat_t       stat_wd;

  always_comb begin
    active  = ~sel_a_n & sel_b & pwr_n;
    tag_we  = active & ~tag_wr_n;
    stat_we = active & ~stat_wr_n;
    stat_wd = ctag_stat_t'(stat_in);
  end

  ctag_tag_mem #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tag_mem (
    .clk   (clk),
    .we    (tag_we),
    .addr  (addr),
    .wdata (tag_in),
    .rdata (tag_rd)
  );

  ctag_stat_array #(.ADDR_W(ADDR_W)) u_stat (
    .clk   (clk),
    .clr_n (clr_n),
    .we    (stat_we),
    .addr  (addr),
    .wdata (stat_wd),
    .rdata (stat_rd)
  );

  ctag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .active       (active),
    .generic_mode (generic_mode),
    .stored_valid (stat_rd.valid),
    .stored_tag   (tag_rd),
    .probe_tag    (tag_in),
    .hit          (hit)
  );

  always_comb begin
    tag_out     = tag_we  ? tag_in  : tag_rd;
    stat_out    = stat_we ? stat_in : STAT_W'(stat_rd);
    tag_out_en  = active & ~tag_oe_n;
    stat_out_en = active & ~stat_oe_n;
    hit_en      = active;
  end
endmodule

// File: rtl/ctag_store_chk.sv
`timescale 1ns/1ps
module ctag_store_chk
  import ctag_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input logic              clk,
  input logic              clr_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              pwr_n,
  input logic              generic_mode,
  input logic [ADDR_W-1:0] addr,
  input logic [TAG_W-1:0]  tag_in,
  input logic              tag_wr_n,
  input logic              stat_wr_n,
  input logic              tag_oe_n,
  input logic              stat_oe_n,
  input logic [TAG_W-1:0]  tag_out,
  input logic              tag_out_en,
  input logic [STAT_W-1:0] stat_out,
  input logic              stat_out_en,
  input logic              hit,
  input logic              hit_en
);
  logic on;
  assign on = !sel_a_n && sel_b && pwr_n;

  // R9: an inactive block drives nothing and reports no hit
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!clr_n)
    !on |-> (!hit && !hit_en && !tag_out_en && !stat_out_en));

  // R8: the cycle after a clear, any line reads all-zero status
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(!clr_n) && stat_wr_n && stat_out_en) |-> (stat_out == '0));

  // R3: a visible invalid line in dedicated mode never hits
  a_r3_invalid_no_hit: assert property (@(posedge clk) disable iff (!clr_n)
    (!generic_mode && stat_out_en && stat_wr_n && !stat_out[VALID_BIT]) |-> !hit);

  // R2: a visible stored tag different from the probe never hits
  a_r2_mismatch: assert property (@(posedge clk) disable iff (!clr_n)
    (tag_out_en && tag_wr_n && (tag_out != tag_in)) |-> !hit);

  // R5: a tag written at one edge reads back at the same address next cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(on && !tag_wr_n) && $stable(addr) && tag_wr_n && tag_out_en)
      |-> (tag_out == $past(tag_in)));

  // R7: the tag drive flag never rises while its enable is high
  a_r7_tag_oe: assert property (@(posedge clk) disable iff (!clr_n)
    tag_oe_n |-> !tag_out_en);
endmodule

bind ctag_store ctag_store_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .clr_n(clr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .pwr_n(pwr_n),
  .generic_mode(generic_mode), .addr(addr), .tag_in(tag_in),
  .tag_wr_n(tag_wr_n), .stat_wr_n(stat_wr_n), .tag_oe_n(tag_oe_n),
  .stat_oe_n(stat_oe_n), .tag_out(tag_out), .tag_out_en(tag_out_en),
  .stat_out(stat_out), .stat_out_en(stat_out_en), .hit(hit), .hit_en(hit_en)
);

// File: tb/ctag_store_bench.sv
`timescale 1ns/1ps
module ctag_store_bench;
  localparam int AW = 8;
  localparam int TW = 12;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          clr_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, pwr_n = 1'b1;
  logic          generic_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [TW-1:0] tag_in = '0;
  logic [2:0]    stat_in = '0;
  logic          tag_wr_n = 1'b1, stat_wr_n = 1'b1, tag_oe_n = 1'b1, stat_oe_n = 1'b1;
  logic [TW-1:0] tag_out;
  logic [2:0]    stat_out;
  logic          tag_out_en, stat_out_en, hit, hit_en;

  ctag_store #(.ADDR_W(AW), .TAG_W(TW)) u_ctag_store (
    .clk(clk), .clr_n(clr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .pwr_n(pwr_n),
    .generic_mode(generic_mode), .addr(addr), .tag_in(tag_in), .stat_in(stat_in),
    .tag_wr_n(tag_wr_n), .stat_wr_n(stat_wr_n), .tag_oe_n(tag_oe_n),
    .stat_oe_n(stat_oe_n), .tag_out(tag_out), .tag_out_en(tag_out_en),
    .stat_out(stat_out), .stat_out_en(stat_out_en), .hit(hit), .hit_en(hit_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit init_phase = 1'b1;
  bit done = 1'b0;
  logic [TW-1:0] tag_m [N];
  logic [2:0]    st_m  [N];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic on, logic gen, logic [AW-1:0] a, logic [TW-1:0] t);
    return on && (tag_m[a] == t) && (gen || st_m[a][0]);
  endfunction

  function automatic string hit_req(logic on, logic twn, logic gen, logic [AW-1:0] a, logic [TW-1:0] t);
    if (!on) return "R9 hit";
    if (!twn) return "R11 hit during tag write";
    if (tag_m[a] != t) return "R2 hit";
    if (gen) return "R4 hit";
    if (!st_m[a][0]) return "R3 hit";
    return "R1 hit";
  endfunction

  task automatic cyc(logic sa_n, logic sb, logic pn, logic gen, logic cn,
                     logic twn, logic swn, logic toen, logic soen,
                     logic [AW-1:0] a, logic [TW-1:0] t, logic [2:0] s);
    logic on;
    @(negedge clk);
    sel_a_n = sa_n; sel_b = sb; pwr_n = pn; generic_mode = gen; clr_n = cn;
    tag_wr_n = twn; stat_wr_n = swn; tag_oe_n = toen; stat_oe_n = soen;
    addr = a; tag_in = t; stat_in = s;
    #5;
    on = !sa_n && sb && pn;
    if (!init_phase) begin
      chk(on ? "R9 hit_en" : "R9 hit_en off", 32'(hit_en), 32'(on));
      chk("R7 tag_out_en", 32'(tag_out_en), 32'(on && !toen));
      chk("R7 stat_out_en", 32'(stat_out_en), 32'(on && !soen));
      chk(hit_req(on, twn, gen, a, t), 32'(hit), 32'(exp_hit(on, gen, a, t)));
      if (on && !toen)
        chk(twn ? "R5 tag read" : "R10 tag write-through", 32'(tag_out), 32'(twn ? tag_m[a] : t));
      if (on && !soen)
        chk(swn ? "R5 status read" : "R10 status write-through", 32'(stat_out), 32'(swn ? st_m[a] : s));
    end
    @(posedge clk);
    if (on && !twn) tag_m[a] = t;
    if (!cn) begin
      for (int i = 0; i < N; i++) st_m[i] = 3'b000;
    end else if (on && !swn) begin
      st_m[a] = s;
    end
  endtask

  // plain active read with both outputs enabled
  task automatic rd(logic gen, logic [AW-1:0] a, logic [TW-1:0] t);
    cyc(0, 1, 1, gen, 1, 1, 1, 0, 0, a, t, 3'b000);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < N; i++) st_m[i] = 3'b000;
    // clear while deselected (R8 acts without select)
    cyc(1, 0, 1, 0, 0, 1, 1, 1, 1, '0, '0, '0);
    for (int i = 0; i < N; i++)
      cyc(0, 1, 1, 0, 1, 0, 1, 1, 1, AW'(i), TW'($urandom), 3'b000);
    init_phase = 1'b0;

    // reset state: cleared status reads zero (R8)
    rd(0, 8'd3, tag_m[3]);
    chk("R8 status after clear", 32'(stat_out), 32'd0);

    // R3 / R4 / R1 directed on line 5
    cyc(0, 1, 1, 0, 1, 0, 0, 1, 1, 8'd5, 12'hABC, 3'b110);
    rd(0, 8'd5, 12'hABC);
    chk("R3 invalid line no hit", 32'(hit), 32'd0);
    rd(1, 8'd5, 12'hABC);
    chk("R4 generic hit ignores valid", 32'(hit), 32'd1);
    cyc(0, 1, 1, 0, 1, 1, 0, 1, 1, 8'd5, 12'h000, 3'b001);
    rd(0, 8'd5, 12'hABC);
    chk("R1 valid line hits", 32'(hit), 32'd1);
    chk("R6 tag kept after status write", 32'(tag_out), 32'hABC);

    // R11: compare during tag write uses old tag
    cyc(0, 1, 1, 0, 1, 0, 1, 0, 0, 8'd5, 12'h111, 3'b000);
    chk("R11 no hit on in-flight tag", 32'(hit), 32'd0);
    rd(0, 8'd5, 12'h111);
    chk("R6 status kept after tag write", 32'(stat_out), 32'd1);

    // R8: clear with concurrent status and tag writes on line 7
    cyc(0, 1, 1, 0, 1, 1, 0, 1, 1, 8'd7, 12'h000, 3'b111);
    cyc(0, 1, 1, 0, 0, 0, 0, 1, 1, 8'd7, 12'h123, 3'b111);
    rd(0, 8'd7, 12'h123);
    chk("R8 status write dropped by clear", 32'(stat_out), 32'd0);
    chk("R8 tag write survives clear", 32'(tag_out), 32'h123);
    rd(0, 8'd5, 12'h111);
    chk("R8 other line cleared", 32'(stat_out), 32'd0);

    // R9: writes ignored while deselected or powered down
    cyc(1, 1, 1, 0, 1, 0, 0, 0, 0, 8'd9, 12'hFFF, 3'b111);
    cyc(0, 1, 0, 0, 1, 0, 0, 0, 0, 8'd9, 12'hEEE, 3'b111);
    rd(0, 8'd9, 12'h000);
    chk("R9 deselected write ignored", 32'(tag_out), 32'(tag_m[9]));
    chk("R9 deselected status write ignored", 32'(stat_out), 32'd0);

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] a;
      logic [TW-1:0] t;
      a = AW'($urandom_range(0, 15));
      t = ($urandom_range(0, 1) == 1) ? tag_m[a] : TW'($urandom);
      cyc(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0),
          ($urandom_range(0, 7) != 0), 1'($urandom), ($urandom_range(0, 63) != 0),
          ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0),
          1'($urandom), 1'($urandom), a, t, 3'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule